// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Driver

This block holds a small configuration register that assigns each of two request sources (one per conversion queue) a programmable 5-bit interrupt level from 0 to 31. It presents the pending requests on an 8-line interrupt bus that is shared over four time slots. A level selects one slot and one line within that slot, and the line is driven only while the slot selector names that slot.

The register is reached through a simple strobe/write-enable port qualified by a supervisor flag. Accesses without the supervisor flag cannot change the register. A read without the flag returns zero and raises a one-cycle access-error pulse. No priority is applied between the two sources: every pending source drives its line, and the bus value is registered.

Top module: `irq_slot_driver`

## Requirements
- R1: After reset the register reads 0x0000, `irq_bus` is 0 and `acc_err` is 0.
- R2: Register layout in LSB-first bit numbering: queue 1 level in `wdata/rdata[15:11]`, queue 2 level in `[10:6]`, bits `[5:0]` reserved. Reserved bits always read 0 whatever was written.
- R3: A write (`acc_en`=1, `acc_wr`=1) with `acc_sup`=1 updates both level fields at the clock edge. With `acc_sup`=0 the write is ignored and the register keeps its value.
- R4: A read (`acc_en`=1, `acc_wr`=0) with `acc_sup`=1 puts the register image on `rdata` one clock later, with `acc_err`=0. With `acc_sup`=0, `rdata` is 0 and `acc_err` is 1 one clock later, for that one cycle only. `rdata` is 0 in cycles that follow no read.
- R5: A pending source with level L drives only `irq_bus` bit L[2:0`], and only while `slot_sel` equals L[4:3].
- R6: Level codes cover 0 (00000, slot 0 line 0) through 31 (11111, slot 3 line 7), and the two queues hold independent levels.
- R7: A source whose pending flag (`pend[0]` queue 1, `pend[1]` queue 2) is 0 drives nothing. With no flag set, `irq_bus` is 0.
- R8: With both sources pending, both lines are driven in the same cycle. When the levels are equal the single shared line is driven.
- R9: `irq_bus` is registered. It reflects `slot_sel`, `pend` and the levels one clock after they are presented.
- R10: A register write in the same cycle that a bus value is formed takes effect on the bus only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sup | input | 1 | Supervisor qualifier for the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| acc_err | output | 1 | One-cycle pulse after a read without the supervisor flag |
| slot_sel | input | 2 | Time slot currently on the bus |
| pend | input | 2 | Pending flags, bit 0 queue 1, bit 1 queue 2 |
| irq_bus | output | 8 | Registered interrupt lines for the current slot |

## Verification
A register write and the forming of the bus value can fall in the same clock edge, and a write can change a level that a pending source is already driving. The bench provokes this by writing a new level while a source is pending and the slot selector names the old level's slot. It then judges the bus one edge later against the old level and after the next edge against the new one. It also sweeps all four slots with both queues pending at different and at equal levels, so that the two sources' lines must coexist on the bus.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;

   typedef enum logic [2:0] {
      ACC_NONE   = 3'd0,
      ACC_RD     = 3'd1,
      ACC_WR     = 3'd2,
      ACC_BAD_RD = 3'd3,
      ACC_BAD_WR = 3'd4
   } acc_kind_e;

   function automatic acc_kind_e classify_access(input logic en, input logic wr,
                                                 input logic sup);
      acc_kind_e k;
      if (!en)          k = ACC_NONE;
      else if (wr &&  sup) k = ACC_WR;
      else if (wr && !sup) k = ACC_BAD_WR;
      else if (sup)     k = ACC_RD;
      else              k = ACC_BAD_RD;
      return k;
   endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
   import irq_slot_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int LEVEL_W = 5,
   parameter int NUM_SRC = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_en,
   input  logic                        acc_wr,
   input  logic                        acc_sup,
   input  logic [REG_W-1:0]            wdata,
   output logic [REG_W-1:0]            rdata,
   output logic                        acc_err,
   output logic [NUM_SRC*LEVEL_W-1:0]  lvl_flat
);
   localparam int USED_W = NUM_SRC * LEVEL_W;
   localparam int RSV_W  = REG_W - USED_W;

   generate
      if (RSV_W < 0) begin : g_bad_w
         $error("irq_cfg_reg: register too narrow for all level fields");
      end
   endgenerate

   acc_kind_e            kind;
   logic [LEVEL_W-1:0]   lvl_q [NUM_SRC];
   logic [REG_W-1:0]     image;

   assign kind = classify_access(acc_en, acc_wr, acc_sup);

   // Fields packed from the top of the word downwards, source 0 highest.
   always_comb begin
      image = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         image[REG_W-1-i*LEVEL_W -: LEVEL_W] = lvl_q[i];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_fld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvl_q[gi] <= '0;
            else if (kind == ACC_WR)
               lvl_q[gi] <= wdata[REG_W-1-gi*LEVEL_W -: LEVEL_W];
         end
         assign lvl_flat[gi*LEVEL_W +: LEVEL_W] = lvl_q[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         acc_err <= 1'b0;
      end else begin
         rdata   <= (kind == ACC_RD) ? image : '0;
         acc_err <= (kind == ACC_BAD_RD);
      end
   end

   generate
      if (RSV_W > 0) begin : g_rsv_chk
         AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rdata[RSV_W-1:0] == '0); // R2
      end
   endgenerate

   AST_NONSUP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && !acc_sup) |=> $stable(lvl_flat)); // R3

   AST_NONSUP_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && !acc_sup) |=> (acc_err && rdata == '0)); // R4

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(acc_en && !acc_wr && !acc_sup)) |=> !acc_err); // R4

endmodule

// File: rtl/irq_level_decode.sv
module irq_level_decode #(
   parameter int LEVEL_W = 5,
   parameter int BUS_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] level,
   input  logic               pending,
   input  logic [LEVEL_W-$clog2(BUS_W)-1:0] slot,
   output logic [BUS_W-1:0]   lines
);
   localparam int LINE_W = $clog2(BUS_W);
   localparam int SLOT_W = LEVEL_W - LINE_W;

   generate
      if (BUS_W != (1 << LINE_W)) begin : g_bad_bus
         $error("irq_level_decode: bus width must be a power of two");
      end
      if (SLOT_W < 1) begin : g_bad_slot
         $error("irq_level_decode: level too narrow to name a slot");
      end
   endgenerate

   logic [SLOT_W-1:0] lvl_slot;
   logic [LINE_W-1:0] lvl_line;
   logic              slot_hit;

   assign lvl_slot = level[LEVEL_W-1 -: SLOT_W];
   assign lvl_line = level[LINE_W-1:0];
   assign slot_hit = pending && (lvl_slot == slot);

   always_comb begin
      lines = '0;
      if (slot_hit) lines[lvl_line] = 1'b1;
   end

   AST_DEC_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lines)); // R5

   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> lines == '0); // R7

endmodule

// File: rtl/irq_slot_driver.sv
module irq_slot_driver #(
   parameter int REG_W   = 16,
   parameter int LEVEL_W = 5,
   parameter int BUS_W   = 8,
   parameter int NUM_SRC = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                acc_en,
   input  logic                                acc_wr,
   input  logic                                acc_sup,
   input  logic [REG_W-1:0]                    wdata,
   output logic [REG_W-1:0]                    rdata,
   output logic                                acc_err,
   input  logic [LEVEL_W-$clog2(BUS_W)-1:0]    slot_sel,
   input  logic [NUM_SRC-1:0]                  pend,
   output logic [BUS_W-1:0]                    irq_bus
);
   localparam int LINE_W = $clog2(BUS_W);
   localparam int SLOT_W = LEVEL_W - LINE_W;

   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("irq_slot_driver: need at least one source");
      end
   endgenerate

   logic [NUM_SRC*LEVEL_W-1:0] lvl_flat;
   logic [BUS_W-1:0]           src_lines [NUM_SRC];
   logic [BUS_W-1:0]           bus_d;

   irq_cfg_reg #(
      .REG_W   (REG_W),
      .LEVEL_W (LEVEL_W),
      .NUM_SRC (NUM_SRC)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .acc_sup  (acc_sup),
      .wdata    (wdata),
      .rdata    (rdata),
      .acc_err  (acc_err),
      .lvl_flat (lvl_flat)
   );

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
         irq_level_decode #(
            .LEVEL_W (LEVEL_W),
            .BUS_W   (BUS_W)
         ) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .level   (lvl_flat[gs*LEVEL_W +: LEVEL_W]),
            .pending (pend[gs]),
            .slot    (slot_sel),
            .lines   (src_lines[gs])
         );
      end
   endgenerate

   // No priority: every requesting source contributes its line.
   always_comb begin
      bus_d = '0;
      for (int i = 0; i < NUM_SRC; i++) bus_d = bus_d | src_lines[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_bus <= '0;
      else        irq_bus <= bus_d;
   end

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> (irq_bus == '0)); // R7

   AST_IRQ_LINE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq_bus) <= NUM_SRC); // R8

   AST_IRQ_FOLLOWS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(bus_d) |=> (irq_bus == $past(bus_d))); // R9

endmodule

// File: tb/irq_slot_driver_bench.sv
module irq_slot_driver_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, acc_sup = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        acc_err;
   logic [1:0]  slot_sel = '0;
   logic [1:0]  pend = '0;
   logic [7:0]  irq_bus;

   int n_chk = 0;
   int n_bad = 0;
   logic [4:0] cur_l1 = '0, cur_l2 = '0;

   always #2.5 clk = ~clk;

   irq_slot_driver u_irq_slot_driver (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_sup(acc_sup), .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
      .slot_sel(slot_sel), .pend(pend), .irq_bus(irq_bus)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_bus(input logic [4:0] l1, input logic [4:0] l2,
                                          input logic [1:0] p, input logic [1:0] s);
      logic [7:0] b = '0;
      if (p[0] && l1[4:3] == s) b[l1[2:0]] = 1'b1;
      if (p[1] && l2[4:3] == s) b[l2[2:0]] = 1'b1;
      return b;
   endfunction

   // One clock: drive at falling edge, sample just after the rising edge.
   task automatic step(input logic en, input logic wr, input logic sup,
                       input logic [15:0] d, input logic [1:0] s, input logic [1:0] p);
      @(negedge clk);
      acc_en = en; acc_wr = wr; acc_sup = sup; wdata = d; slot_sel = s; pend = p;
      @(posedge clk);
      #1;
   endtask

   task automatic sup_write(input logic [4:0] l1, input logic [4:0] l2, input logic [5:0] rsv);
      step(1, 1, 1, {l1, l2, rsv}, slot_sel, pend);
      cur_l1 = l1; cur_l2 = l2;
   endtask

   task automatic t_reset;
      chk("R1 rdata after reset", rdata, 0);
      chk("R1 irq_bus after reset", irq_bus, 0);
      chk("R1 acc_err after reset", acc_err, 0);
      step(1, 0, 1, '0, 0, 0);
      chk("R1 register reads zero", rdata, 0);
   endtask

   task automatic t_layout;
      sup_write(5'h1F, 5'h1F, 6'h3F);
      step(1, 0, 1, '0, 0, 0);
      chk("R2 reserved read zero", rdata, 16'hFFC0);
      chk("R4 sup read no error", acc_err, 0);
      sup_write(5'h15, 5'h0A, 6'h2A);
      step(1, 0, 1, '0, 0, 0);
      chk("R2 field positions", rdata, {5'h15, 5'h0A, 6'h00});
      step(0, 0, 0, '0, 0, 0);
      chk("R4 idle rdata zero", rdata, 0);
   endtask

   task automatic t_access;
      step(1, 1, 0, 16'h1234, 0, 0);
      step(1, 0, 1, '0, 0, 0);
      chk("R3 nonsup write ignored", rdata, {5'h15, 5'h0A, 6'h00});
      step(1, 0, 0, '0, 0, 0);
      chk("R4 nonsup read rdata", rdata, 0);
      chk("R4 nonsup read error", acc_err, 1);
      step(0, 0, 0, '0, 0, 0);
      chk("R4 error one cycle", acc_err, 0);
   endtask

   task automatic t_sweep(input logic [4:0] l1, input logic [4:0] l2, input string tag);
      sup_write(l1, l2, 6'h00);
      for (int p = 0; p < 4; p++) begin
         for (int s = 0; s < 4; s++) begin
            step(0, 0, 0, '0, 2'(s), 2'(p));
            chk(tag, irq_bus, exp_bus(l1, l2, 2'(p), 2'(s)));
         end
      end
   endtask

   task automatic t_latency;
      sup_write(5'd13, 5'd31, 6'h00);   // slot1 line5, slot3 line7
      step(0, 0, 0, '0, 2'd1, 2'b11);
      chk("R9 settled slot1", irq_bus, 8'h20);
      @(negedge clk);
      slot_sel = 2'd3;
      #1;
      chk("R9 unchanged before edge", irq_bus, 8'h20);
      @(posedge clk); #1;
      chk("R9 slot3 after edge", irq_bus, 8'h80);
   endtask

   task automatic t_same_cycle;
      // Queue 1 at level 9 (slot1 line1) pending; rewrite it to level 12 (slot1 line4).
      sup_write(5'd9, 5'd0, 6'h00);
      step(0, 0, 0, '0, 2'd1, 2'b01);
      chk("R10 before write", irq_bus, 8'h02);
      step(1, 1, 1, {5'd12, 5'd0, 6'h00}, 2'd1, 2'b01);
      chk("R10 edge of write uses old level", irq_bus, 8'h02);
      step(0, 0, 0, '0, 2'd1, 2'b01);
      chk("R10 next edge uses new level", irq_bus, 8'h10);
      step(0, 0, 0, '0, 2'd1, 2'b00);
      chk("R7 flags cleared", irq_bus, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_layout();
      t_access();
      t_sweep(5'd5,  5'd26, "R5 R7 R8 distinct levels");
      t_sweep(5'd0,  5'd31, "R6 extreme levels");
      t_sweep(5'd19, 5'd19, "R8 equal levels");
      t_latency();
      t_same_cycle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule